// File: doc/BRIEF.md
# GF(2^m) Almost-Inverse Field Inverter

This block computes the multiplicative inverse of a nonzero element of the binary extension field GF(2^m). It runs a binary extended-Euclid style loop in which every division of the working polynomial u(x) by x is matched by a division of the cofactor b(x) by x. When b(x) is odd, the modulus is added to it before that halving. When u(x) reaches the unity polynomial, b(x) already holds the inverse, so no correction by a power of x is needed afterwards.

A caller places the operand and the modulus on the inputs and pulses `start` while the block is idle. The modulus is sampled with the operand, so it may change from one operation to the next. The block performs one step per clock: a halving, a compare/swap/add, or the final unity test. It then shows the inverse on `inv` with a one-cycle `done` pulse. A zero operand, or a loop that runs past its cycle budget (only possible with a reducible modulus), ends with `err` set and `inv` cleared.

The controller has two named states. ST_IDLE waits for `start`. Its transitions are IDLE->IDLE (zero operand, immediate error completion) and IDLE->RUN (operand loaded). ST_RUN executes one step per cycle. It stays in RUN for a halving or a merge step, and takes RUN->IDLE either on unity (success) or on guard expiry (error).

Top module: `gfinv_top`

## Requirements
- R1: After reset, and after any reset applied mid-operation, `done`=0, `err`=0, `inv`=0, and the block accepts a `start` on the next cycle.
- R2: For a nonzero operand a and an irreducible modulus f (bit m set, constant term 1), the completion shows `err`=0 and `inv`=b with a·b mod f = 1. This holds for every parameter value, including M=8 and M=16.
- R3: A `start` with operand 0 sets `done`=1, `err`=1 and `inv`=0 in the very next cycle, and no loop is run.
- R4: `done` is high for exactly one cycle per completion.
- R5: A `start` that arrives while an operation is running is ignored, and so are changes to `op_a` or `modulus`. The running result is that of the operands sampled by the accepted start.
- R6: `inv` and `err` keep their values from one completion until the next completion.
- R7: With `start` sampled at clock edge k, operand 1 completes at edge k+1 and operand x (value 2) at edge k+2. No operand needs more than 4m step cycles.
- R8: If u does not reach 1 within 4m step cycles, the operation ends with `done`=1, `err`=1 and `inv`=0. An example is f = x^8+1 with a = x+1.
- R9: The modulus is taken from the `modulus` port at each accepted start, so a different irreducible polynomial gives the inverse in that field. With f = x^8+x^4+x^3+x^2+1, the inverse of x is 0x8E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an inversion (sampled only in idle) |
| op_a | input | M | Operand a(x), bit i is the coefficient of x^i |
| modulus | input | M+1 | Field polynomial f(x), bit M must be set |
| inv | output | M | Inverse of the last completed operation, 0 on error |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last completion failed (zero operand or guard expiry) |

## Verification
Two events can share a cycle: the completion of one operation (the `done` pulse with the controller already back in idle) and the acceptance of the next `start`. The bench provokes this in two steps. It first finishes a zero-operand request, then drives a new nonzero start in the very cycle `done` is observed high. The new start must be accepted: the following completion must carry the correct inverse with `err` cleared. The earlier error must not leak into it. The opposite case, a start landing one cycle into a running operation, is also driven, and the bench judges it by the result matching the first operand.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

    // Controller states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } gfinv_state_e;

    // Datapath operation selected by the controller for the current cycle
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_LOAD   = 3'd1,
        OP_SHIFT  = 3'd2,
        OP_MERGE  = 3'd3,
        OP_FINISH = 3'd4,
        OP_FAIL   = 3'd5
    } gfinv_op_e;

endpackage

// File: rtl/gfinv_msb.sv
// Index of the highest set bit of a polynomial vector (0 for an all-zero vector).
module gfinv_msb #(
    parameter int W  = 9,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/gfinv_halve.sv
// Divide a cofactor by x modulo f: add f first when the constant term is 1.
module gfinv_halve #(
    parameter int W = 9
) (
    input  logic [W-1:0] bin,
    input  logic [W-1:0] fpoly,
    output logic [W-1:0] bout
);
    logic [W-1:0] even_val;

    always_comb begin
        even_val = bin[0] ? (bin ^ fpoly) : bin;
        bout     = even_val >> 1;
    end
endmodule

// File: rtl/gfinv_fsm.sv
// Sequencing of the inversion loop: one operation per cycle.
module gfinv_fsm
    import gfinv_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         a_zero,
    input  logic         u_unit,
    input  logic         u_even,
    input  logic         guard_hit,
    output gfinv_state_e state,
    output gfinv_op_e    op
);
    gfinv_state_e nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transition and operation decode
    always_comb begin
        nxt = state;
        op  = OP_NONE;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (a_zero) begin
                        op = OP_FAIL;          // IDLE -> IDLE, zero operand
                    end else begin
                        op  = OP_LOAD;         // IDLE -> RUN
                        nxt = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (u_unit) begin
                    op  = OP_FINISH;           // RUN -> IDLE, success
                    nxt = ST_IDLE;
                end else if (guard_hit) begin
                    op  = OP_FAIL;             // RUN -> IDLE, budget spent
                    nxt = ST_IDLE;
                end else if (u_even) begin
                    op = OP_SHIFT;             // RUN -> RUN, halve
                end else begin
                    op = OP_MERGE;             // RUN -> RUN, compare/swap/add
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/gfinv_top.sv
// GF(2^m) inverter top: polynomial registers, degree compare and output stage.
module gfinv_top
    import gfinv_pkg::*;
#(
    parameter int M = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] op_a,
    input  logic [M:0]   modulus,
    output logic [M-1:0] inv,
    output logic         done,
    output logic         err
);
    localparam int W     = M + 1;
    localparam int IW    = $clog2(W);
    localparam int LIMIT = 4 * M;
    localparam int CW    = $clog2(LIMIT + 1);

    gfinv_state_e state;
    gfinv_op_e    op;

    logic [W-1:0]  u_q, v_q, b_q, c_q, f_q;
    logic [CW-1:0] cnt_q;
    logic [M-1:0]  inv_q;
    logic          done_q, err_q;

    logic [W-1:0]  b_half;
    logic          u_unit, u_even, a_zero, guard_hit, swap;

    // Degree units for u (slot 0) and v (slot 1)
    logic [1:0][W-1:0]  deg_in;
    logic [1:0][IW-1:0] deg_out;

    assign deg_in[0] = u_q;
    assign deg_in[1] = v_q;

    for (genvar g = 0; g < 2; g++) begin : g_deg
        gfinv_msb #(.W(W), .IW(IW)) u_msb (
            .vec (deg_in[g]),
            .idx (deg_out[g])
        );
    end

    gfinv_halve #(.W(W)) u_halve (
        .bin   (b_q),
        .fpoly (f_q),
        .bout  (b_half)
    );

    assign u_unit    = (u_q == W'(1));
    assign u_even    = ~u_q[0];
    assign a_zero    = (op_a == '0);
    assign guard_hit = (cnt_q == CW'(LIMIT));
    assign swap      = (deg_out[0] < deg_out[1]);

    gfinv_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .a_zero    (a_zero),
        .u_unit    (u_unit),
        .u_even    (u_even),
        .guard_hit (guard_hit),
        .state     (state),
        .op        (op)
    );

    // Polynomial registers and step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            u_q   <= '0;
            v_q   <= '0;
            b_q   <= '0;
            c_q   <= '0;
            f_q   <= '0;
            cnt_q <= '0;
        end else begin
            unique case (op)
                OP_LOAD: begin
                    u_q   <= {1'b0, op_a};
                    v_q   <= modulus;
                    b_q   <= W'(1);
                    c_q   <= '0;
                    f_q   <= modulus;
                    cnt_q <= '0;
                end
                OP_SHIFT: begin
                    u_q   <= u_q >> 1;
                    b_q   <= b_half;
                    cnt_q <= cnt_q + 1'b1;
                end
                OP_MERGE: begin
                    u_q <= u_q ^ v_q;
                    b_q <= b_q ^ c_q;
                    if (swap) begin
                        v_q <= u_q;
                        c_q <= b_q;
                    end
                    cnt_q <= cnt_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (op == OP_FINISH) begin
                inv_q  <= b_q[M-1:0];
                err_q  <= 1'b0;
                done_q <= 1'b1;
            end else if (op == OP_FAIL) begin
                inv_q  <= '0;
                err_q  <= 1'b1;
                done_q <= 1'b1;
            end
        end
    end

    assign inv  = inv_q;
    assign done = done_q;
    assign err  = err_q;

endmodule

// File: rtl/gfinv_chk.sv
// Property checker attached to the inverter top.
module gfinv_chk
    import gfinv_pkg::*;
#(
    parameter int M  = 8,
    parameter int W  = M + 1,
    parameter int CW = $clog2(4 * M + 1)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [M-1:0] op_a,
    input logic [M-1:0] inv,
    input logic         done,
    input logic         err,
    input gfinv_state_e state,
    input logic [W-1:0] u_q,
    input logic [W-1:0] f_q,
    input logic [CW-1:0] cnt_q
);
    localparam int LIMIT = 4 * M;

    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start && op_a == '0) |=> (done && err && inv == '0)); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done); // R4

    AST_BUSY_MODULUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(f_q)); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(inv) && $stable(err))); // R6

    AST_UNITY_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && u_q == W'(1)) |=> (done && !err)); // R2

    AST_MERGE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && u_q[0] && u_q != W'(1) && cnt_q != CW'(LIMIT) && f_q[0])
        |=> !u_q[0]); // R2

    AST_GUARD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT)); // R8

    AST_GUARD_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && cnt_q == CW'(LIMIT) && u_q != W'(1)) |=> (done && err)); // R8

endmodule

bind gfinv_top gfinv_chk #(.M(M)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .op_a  (op_a),
    .inv   (inv),
    .done  (done),
    .err   (err),
    .state (state),
    .u_q   (u_q),
    .f_q   (f_q),
    .cnt_q (cnt_q)
);

// File: tb/gfinv_top_test.sv
`timescale 1ns/1ps
module gfinv_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  op_a = '0;
    logic [8:0]  modulus = 9'h11B;
    logic [7:0]  inv;
    logic        done, err;

    logic        w_start = 1'b0;
    logic [15:0] w_a = '0;
    logic [16:0] w_mod = 17'h1002B;
    logic [15:0] w_inv;
    logic        w_done, w_err;

    int total = 0;
    int bad = 0;
    int ticks = 0;

    always #2.5 clk = ~clk;

    gfinv_top #(.M(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a),
        .modulus(modulus), .inv(inv), .done(done), .err(err)
    );

    gfinv_top #(.M(16)) uut_w (
        .clk(clk), .rst_n(rst_n), .start(w_start), .op_a(w_a),
        .modulus(w_mod), .inv(w_inv), .done(w_done), .err(w_err)
    );

    // {err, a, f, inv}
    localparam logic [25:0] VEC [7] = '{
        {1'b0, 8'h53, 9'h11B, 8'hCA},
        {1'b0, 8'hCA, 9'h11B, 8'h53},
        {1'b0, 8'h01, 9'h11B, 8'h01},
        {1'b0, 8'h02, 9'h11B, 8'h8D},
        {1'b0, 8'h02, 9'h11D, 8'h8E},
        {1'b1, 8'h00, 9'h11B, 8'h00},
        {1'b1, 8'h03, 9'h101, 8'h00}
    };

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [16:0] gmul(input logic [16:0] x, input logic [16:0] y,
                                         input logic [16:0] f, input int m);
        logic [16:0] acc;
        logic [16:0] t;
        acc = '0;
        t   = x;
        for (int i = 0; i < m; i++) begin
            if (y[i]) acc = acc ^ t;
            t = t << 1;
            if (t[m]) t = t ^ f;
        end
        return acc;
    endfunction

    task automatic run8(input logic [7:0] a, input logic [8:0] f, output int cyc);
        @(negedge clk);
        start = 1'b1; op_a = a; modulus = f; cyc = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end while (!done && cyc < 300);
    endtask

    task automatic runw(input logic [15:0] a, output int cyc);
        @(negedge clk);
        w_start = 1'b1; w_a = a; cyc = 0;
        do begin
            @(negedge clk);
            w_start = 1'b0;
            cyc++;
        end while (!w_done && cyc < 300);
    endtask

    task automatic finish_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        ticks++;
        if (ticks > 150000) begin
            total++;
            bad++;
            $display("FAIL R7 watchdog actual=%0d expected<%0d", ticks, 150000);
            finish_run();
        end
    end

    initial begin
        int cyc;
        string tag;
        logic [7:0] ea;
        logic [8:0] ef;

        repeat (3) @(negedge clk);
        check(done == 1'b0 && err == 1'b0 && inv == 8'h00, "R1 reset outputs",
              {inv, 6'b0, err, done}, 0);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < 7; i++) begin
            ea = VEC[i][24:17];
            ef = VEC[i][16:8];
            run8(ea, ef, cyc);
            if (VEC[i][25] && ea == 8'h00)  tag = "R3";
            else if (VEC[i][25])            tag = "R8";
            else if (ef != 9'h11B)          tag = "R9";
            else                            tag = "R2";
            check(done && inv == VEC[i][7:0] && err == VEC[i][25],
                  tag, {err, inv}, {VEC[i][25], VEC[i][7:0]});
            if (ea == 8'h00) check(cyc == 1, "R3 latency", cyc, 1);
            if (ea == 8'h01) check(cyc == 2, "R7 latency of one", cyc, 2);
            if (ea == 8'h02 && ef == 9'h11B) check(cyc == 3, "R7 latency of x", cyc, 3);
            @(negedge clk);
            check(done == 1'b0, "R4 single pulse", done, 0);
        end

        // Every nonzero element of GF(2^8)
        for (int a = 1; a < 256; a++) begin
            run8(8'(a), 9'h11B, cyc);
            check(done && !err && gmul(17'(a), 17'(inv), 17'h11B, 8) == 17'h1,
                  "R2 exhaustive", {a[7:0], inv}, {a[7:0], 8'h00});
            check(cyc <= 33, "R7 bound", cyc, 33);
        end

        // Hold between completions
        run8(8'h53, 9'h11B, cyc);
        op_a = 8'h07; modulus = 9'h11D;
        repeat (6) @(negedge clk);
        check(inv == 8'hCA && err == 1'b0 && done == 1'b0, "R6 hold result", {err, inv}, 9'h0CA);
        run8(8'h00, 9'h11B, cyc);
        repeat (4) @(negedge clk);
        check(inv == 8'h00 && err == 1'b1, "R6 hold error", {err, inv}, 9'h100);

        // Start while busy
        @(negedge clk);
        start = 1'b1; op_a = 8'h53; modulus = 9'h11B;
        @(negedge clk);
        op_a = 8'h02; modulus = 9'h11D;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 300) begin @(negedge clk); cyc++; end
        check(inv == 8'hCA && !err, "R5 busy start ignored", inv, 8'hCA);

        // Start in the same cycle as the previous done
        @(negedge clk);
        start = 1'b1; op_a = 8'h00; modulus = 9'h11B;
        @(negedge clk);
        check(done && err, "R3 zero before overlap", {done, err}, 2'b11);
        op_a = 8'hCA;
        cyc = 0;
        do begin @(negedge clk); start = 1'b0; cyc++; end while (!done && cyc < 300);
        check(inv == 8'h53 && !err, "R4 start during done accepted", {err, inv}, 9'h053);

        // Reset in the middle of a run
        @(negedge clk);
        start = 1'b1; op_a = 8'h53;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(done == 1'b0 && err == 1'b0 && inv == 8'h00, "R1 mid-run reset",
              {inv, err, done}, 0);
        rst_n = 1'b1;
        run8(8'h01, 9'h11B, cyc);
        check(inv == 8'h01 && cyc == 2, "R1 ready after reset", {cyc[7:0], inv}, {8'd2, 8'h01});

        // Wider field, pseudo-random operands
        for (int k = 0; k < 40; k++) begin
            logic [15:0] ra;
            ra = 16'($urandom);
            if (ra == 16'h0) ra = 16'h1;
            runw(ra, cyc);
            check(w_done && !w_err && gmul(17'(ra), 17'(w_inv), 17'h1002B, 16) == 17'h1,
                  "R2 wide field", {ra, w_inv}, {ra, 16'h0});
            check(cyc <= 65, "R7 wide bound", cyc, 65);
        end

        finish_run();
    end

endmodule